// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Paged Write Cycle

This block is the slave side of a two-wire serial EEPROM, clocked by a fast system clock that samples the bus clock and data lines. It detects bus Start and Stop events and recognises its own 7-bit address. The upper nibble of that address is fixed at binary 1010, and the low three bits come from strap pins. A write transfer carries a word address byte and then a burst of data bytes. The data bytes are collected in an 8-byte page latch and committed to a 128-byte register array by a self-timed write cycle, which the closing Stop launches.

While the write cycle runs, the slave stays silent on the bus, so a master finds out that the cycle has finished by repeating an address byte until it is acknowledged. A read transfer returns bytes from the current address pointer. The data line is open-drain: `sda_oe` high means the slave pulls the line low.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe` and `busy` are 0 and every memory byte reads 0.
- R2: When not busy, the slave pulls SDA low during the ninth clock of an address byte whose seven high bits equal 1010 followed by `strap_i[2:0]` (MSB first). Bit 0 selects the direction: 0 is write, 1 is read. Any other address byte is left unacknowledged, and the slave then ignores the bus until the next Start.
- R3: In a write, the byte after the address is the word address. Its low 7 bits set the pointer and its bit 7 is ignored. That byte and every data byte after it are acknowledged. Each data byte goes to the pointer location, and then the low 3 pointer bits advance modulo 8 while the upper 4 bits stay fixed.
- R4: If a burst holds more than 8 data bytes, the later bytes wrap to the start of the same page and replace the earlier bytes at the same offsets.
- R5: A Stop that follows at least one complete data byte raises `busy` within 4 system clocks. `busy` then stays high for exactly WR_CYCLES clocks. When `busy` falls, only the page offsets that received data have changed in memory.
- R6: While `busy` is high, no address byte is acknowledged, whether it is a read or a write, and `sda_oe` stays 0.
- R7: A Stop after only a word address byte (no data) starts no write cycle, but the pointer is still set to that address.
- R8: A Start that arrives before the Stop discards every buffered byte of the transfer, and memory keeps its old contents.
- R9: In a read, the slave sends the byte at the pointer MSB first and the pointer advances by one modulo 128. A master ACK fetches the next byte; a master NACK ends the read.
- R10: After a write completes, the pointer holds the page offset that follows the last byte written.
- R11: Start is an SDA fall while SCL is high, and Stop is an SDA rise while SCL is high. `sda_oe` changes only while SCL is low, and a Start releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Low three bits of the slave address |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The bench builds the block with WR_CYCLES set to 1000, while an address byte on the bus takes about 400 system clocks. This lets two complete polling attempts, one write and one read, fall inside a single write cycle and be refused. It also lets the exact cycle length be counted. The default 128-byte array and 8-byte page are kept, so the bench can exercise page wrap, a read that crosses the top of memory, and the ignored bit 7 of the word address.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADR, ST_WADR_ACK,
    ST_DATA, ST_DATA_ACK, ST_RD, ST_RD_ACK
  } twi_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // data edges only count as bus events while the clock stays high
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
  parameter int unsigned PAGE = 8,
  localparam int unsigned OW = $clog2(PAGE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  wr_en,
  input  logic [OW-1:0]         wr_off,
  input  logic [7:0]            wr_data,
  output logic [PAGE-1:0][7:0]  buf_data,
  output logic [PAGE-1:0]       buf_vld,
  output logic                  any_vld
);
  for (genvar i = 0; i < PAGE; i++) begin : g_lane
    logic [7:0] lane_d;
    logic       lane_v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_d <= '0;
        lane_v <= 1'b0;
      end else if (clear) begin
        lane_v <= 1'b0;
      end else if (wr_en && wr_off == OW'(i)) begin
        lane_d <= wr_data;
        lane_v <= 1'b1;
      end
    end
    assign buf_data[i] = lane_d;
    assign buf_vld[i]  = lane_v;
  end

  assign any_vld = |buf_vld;
endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
  parameter int unsigned WR_CYCLES = 200,
  localparam int unsigned CW = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic commit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (launch)     cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy   = (cnt != '0);
  assign commit = (cnt == CW'(1));
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned PAGE  = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned OW = $clog2(PAGE),
  localparam int unsigned PW = AW - OW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [PW-1:0]         page,
  input  logic [PAGE-1:0][7:0]  buf_data,
  input  logic [PAGE-1:0]       buf_vld,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (buf_vld[i]) mem[{page, OW'(i)}] <= buf_data[i];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 200,
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned PAGE      = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned OW = $clog2(PAGE)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe,
  output logic       busy
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic launch, commit;

  twi_state_e     state;
  logic [3:0]     bit_cnt;
  logic [7:0]     shreg;
  logic [AW-1:0]  ptr;
  logic           oe_q, rw_q, mack_q;

  logic [PAGE-1:0][7:0] buf_data;
  logic [PAGE-1:0]      buf_vld;
  logic                 any_vld;
  logic [7:0]           rd_data;

  logic byte_in, byte_done, addr_hit, buf_wr, buf_clr;

  twi_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // a byte has been fully shifted in and the clock has just dropped
  assign byte_in   = (state == ST_DEV) || (state == ST_WADR) || (state == ST_DATA);
  assign byte_done = byte_in && scl_fall && (bit_cnt == 4'd8) && !start_det && !stop_det;
  assign addr_hit  = (shreg[7:1] == {DEV_TYPE, strap_i});
  assign buf_wr    = byte_done && (state == ST_DATA);
  // a Start during a write cycle must not wipe the bytes awaiting commit
  assign buf_clr   = commit || (start_det && !busy);
  assign launch    = stop_det && any_vld && !busy;

  twi_page_buf #(.PAGE(PAGE)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(buf_clr), .wr_en(buf_wr),
    .wr_off(ptr[OW-1:0]), .wr_data(shreg),
    .buf_data(buf_data), .buf_vld(buf_vld), .any_vld(any_vld)
  );

  twi_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .commit(commit)
  );

  twi_mem_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_mem (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page(ptr[AW-1:OW]),
    .buf_data(buf_data), .buf_vld(buf_vld), .rd_addr(ptr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV, ST_WADR, ST_DATA: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            if (state == ST_DEV) begin
              if (addr_hit && !busy) begin
                oe_q  <= 1'b1;
                rw_q  <= shreg[0];
                state <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WADR) begin
              oe_q  <= 1'b1;
              ptr   <= shreg[AW-1:0];
              state <= ST_WADR_ACK;
            end else begin
              oe_q  <= 1'b1;
              ptr   <= {ptr[AW-1:OW], ptr[OW-1:0] + 1'b1};
              state <= ST_DATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              shreg <= rd_data;
              oe_q  <= ~rd_data[7];
              state <= ST_RD;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_WADR;
            end
          end
        end
        ST_WADR_ACK, ST_DATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_DATA;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              oe_q   <= 1'b0;
              ptr    <= ptr + 1'b1;
              mack_q <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              oe_q  <= ~shreg[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            if (sda_s) state <= ST_IDLE;
            else       mack_q <= 1'b1;
          end else if (scl_fall && mack_q) begin
            shreg   <= rd_data;
            oe_q    <= ~rd_data[7];
            bit_cnt <= '0;
            mack_q  <= 1'b0;
            state   <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sda_oe,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic launch,
  input logic commit
);
  a_r6_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  a_r5_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  a_r5_commit_ends_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  a_r11_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
endmodule

bind twi_eeprom_slave twi_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .launch(launch), .commit(commit)
);

// File: tb/tb_twi_eeprom_slave.sv
module tb_twi_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int TB_WR      = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       sda_oe, busy;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] model [128];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       mon_on = 1'b0;
  logic [7:0] mon_sh = '0;
  int         mon_n  = 0;

  assign sda_line = !(m_low || sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_eeprom_slave #(.WR_CYCLES(TB_WR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe(sda_oe), .busy(busy)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // monitor: rebuilds each byte the slave sends and pops the expected item
  always @(posedge scl) begin
    if (mon_on) begin
      mon_sh = {mon_sh[6:0], sda_line};
      mon_n++;
      if (mon_n == 8) begin
        if (exp_q.size() == 0) check("R9 unexpected byte", mon_sh, 0);
        else check(tag_q.pop_front(), mon_sh, exp_q.pop_front());
      end
    end
  end

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; half();
    scl = 1'b1;   half();
    m_low = 1'b1; half();
    scl = 1'b0;   half();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; half();
    scl = 1'b1;   half();
    m_low = 1'b0; half();
  endtask

  task automatic clock_bit(input logic b);
    m_low = !b; half();
    scl = 1'b1; half(); half();
    scl = 1'b0; half();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    m_low = 1'b0; half();
    scl = 1'b1; half();
    ack = !sda_line; half();
    scl = 1'b0; half();
  endtask

  task automatic recv_byte(input logic give_ack);
    m_low = 1'b0;
    mon_n = 0;
    mon_on = 1'b1;
    for (int i = 0; i < 8; i++) begin
      half(); scl = 1'b1; half(); half(); scl = 1'b0;
    end
    mon_on = 1'b0;
    half();
    clock_bit(!give_ack);
    m_low = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
    half();
  endtask

  task automatic set_ptr(input logic [7:0] a, input string tag);
    logic ack;
    bus_start();
    send_byte(dev(1'b0), ack); check({tag, " dev ack"}, ack, 1);
    send_byte(a, ack);         check({tag, " waddr ack"}, ack, 1);
    bus_stop();
  endtask

  task automatic read_n(input int start, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(dev(1'b1), ack); check({tag, " read dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[(start + i) % 128]);
      tag_q.push_back(tag);
      recv_byte(i != n - 1);
    end
    bus_stop();
  endtask

  // write burst; updates the model with page wrap; leaves the Stop to caller
  task automatic write_burst(input logic [7:0] wa, input logic [7:0] d [], input string tag);
    logic ack;
    int off;
    bus_start();
    send_byte(dev(1'b0), ack); check({tag, " wr dev ack"}, ack, 1);
    send_byte(wa, ack);        check({tag, " wr waddr ack"}, ack, 1);
    off = wa[2:0];
    foreach (d[k]) begin
      send_byte(d[k], ack);    check({tag, " data ack"}, ack, 1);
      model[{wa[6:3], 3'(off)}] = d[k];
      off = (off + 1) % 8;
    end
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    int n, lat, polls;
    logic first_w, first_r;
    logic [7:0] d [];

    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 sda_oe", sda_oe, 0);
    check("R1 busy", busy, 0);
    set_ptr(8'h00, "R1 ptr");
    read_n(0, 8, "R1 zero mem");

    // R2 address match
    bus_start(); send_byte(8'hA0, ack); bus_stop();
    check("R2 wrong strap nack", ack, 0);
    bus_start(); send_byte({4'b1011, strap, 1'b0}, ack); bus_stop();
    check("R2 wrong type nack", ack, 0);
    bus_start(); send_byte(dev(1'b0), ack); bus_stop();
    check("R2 match ack", ack, 1);

    // R3/R5 small write with exact cycle length
    d = '{8'h11, 8'h22, 8'h33};
    write_burst(8'h12, d, "R3");
    m_low = 1'b1; half(); scl = 1'b1; half(); m_low = 1'b0;
    lat = 0;
    while (!busy && lat < 10) begin @(negedge clk); lat++; end
    check("R5 busy latency ok", (lat <= 4) ? 1 : 0, 1);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    check("R5 cycle length", n, TB_WR);
    half();
    set_ptr(8'h10, "R5 ptr");
    read_n(16'h10, 8, "R5 only received bytes");

    // R4/R10/R9 burst of 10 from offset 5, then current-address read
    d = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hA8, 8'hA9};
    write_burst(8'h2D, d, "R4");
    bus_stop();
    wait_idle();
    read_n(8'h2F, 2, "R10 ptr after wrap");
    set_ptr(8'h28, "R4 ptr");
    read_n(8'h28, 8, "R4 wrapped page");

    // R6 polling while busy
    d = '{8'h5C};
    write_burst(8'h40, d, "R6");
    bus_stop();
    bus_start(); send_byte(dev(1'b0), first_w); bus_stop();
    bus_start(); send_byte(dev(1'b1), first_r); bus_stop();
    check("R6 write poll nack", first_w, 0);
    check("R6 read poll nack", first_r, 0);
    polls = 0; ack = 1'b0;
    while (!ack && polls < 8) begin
      bus_start(); send_byte(dev(1'b0), ack); bus_stop();
      polls++;
    end
    check("R6 ack after cycle", ack, 1);
    check("R6 busy low at ack", busy, 0);
    set_ptr(8'h40, "R6 ptr");
    read_n(8'h40, 1, "R6 committed");

    // R7 zero data bytes
    set_ptr(8'h2A, "R7");
    repeat (20) @(negedge clk);
    check("R7 no busy", busy, 0);
    read_n(8'h2A, 1, "R7 pointer set");

    // R8 abort by Start mid-byte
    d = '{8'hE1, 8'hE2};
    write_burst(8'h50, d, "R8");
    model[8'h50] = 8'h00; model[8'h51] = 8'h00;
    for (int i = 0; i < 4; i++) clock_bit(1'b1);
    bus_start();
    check("R11 start releases", sda_oe, 0);
    bus_stop();
    repeat (20) @(negedge clk);
    check("R8 no write cycle", busy, 0);
    set_ptr(8'h50, "R8 ptr");
    read_n(8'h50, 3, "R8 memory kept");

    // R9 read wraps at top of memory; R3 bit 7 ignored
    d = '{8'h7A, 8'h7B};
    write_burst(8'hFE, d, "R3 hi bit");
    bus_stop(); wait_idle();
    set_ptr(8'h7E, "R9 ptr");
    read_n(8'h7E, 3, "R9 wrap to zero");

    // R2 strap change
    strap = 3'b010;
    bus_start(); send_byte(8'hA4, ack); bus_stop();
    check("R2 new strap ack", ack, 1);
    bus_start(); send_byte(8'hAA, ack); bus_stop();
    check("R2 old strap nack", ack, 0);

    repeat (20) @(negedge clk);
    check("R9 all bytes seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule